// File: doc/BRIEF.md
# Clock Frequency Measurement Checker

This block checks that a clock runs at roughly the expected rate. It counts cycles of the measured clock over each period of a slow reference clock and compares that count with a programmable lower and upper bound. The reference arrives as a one-cycle tick that is synchronous to the measured clock. The parameter `RATIO` is the nominal number of measured cycles per reference period. A count outside the bounds sets a sticky error flag and sends a one-cycle recoverable alert pulse.

Software controls the block through three write ports.
- A configuration word holds the enable bit and the two thresholds.
- A lock bit freezes that word once it is cleared.
- An error port clears the flag by writing 1.

Each threshold is one bit wider than the bit length of `RATIO`, which leaves room to tune the bounds. After reset the bounds sit ten counts either side of the nominal ratio.

Top module: `clk_freq_checker`

## Requirements
- R1: After reset the checker is disabled, the bounds read back as `RATIO+10` (upper) and `RATIO-10` (lower), the lock bit reads 1, and the error flag and the alert are 0.
- R2: Configuration word layout:
  - bit 0 is the enable;
  - the upper bound occupies bits [4 +: THW], where THW = bitlength(RATIO)+1;
  - the lower bound occupies the THW bits directly above the upper bound;
  - bits 3:1 read back as 0.
- R3: Writing 0 to the lock port clears the lock bit, and writing 1 leaves it unchanged. While the lock bit is 0, configuration writes are ignored. Only reset sets the lock bit again.
- R4: The window count is the number of measured-clock cycles between two consecutive reference ticks. An error is raised when the count is above the upper bound or below the lower bound. A count equal to either bound raises no error.
- R5: The first reference tick after enabling only opens a window, and it never raises an error.
- R6: While the enable bit is 0, the counter is held at zero and no error or alert is raised, whatever the reference ticks do.
- R7: The error flag is sticky. Writing 1 to the error port clears it, and writing 0 has no effect.
- R8: When an error occurs in the same cycle as a clearing write, the error flag stays set.
- R9: The alert is a one-cycle pulse. It appears in the cycle after the violating tick, together with the error flag, and it fires for each violating window even when the flag is already set.
- R10: The counter saturates at 2^(THW+1)-1. A window longer than that gives a count of 2^(THW+1), so an overly long window is still flagged as too slow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Measured clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse marking each reference rising edge |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4+2*THW | Configuration write data |
| lock_wr_i | input | 1 | Lock write strobe |
| lock_wdata_i | input | 1 | Lock write data (0 clears the lock) |
| err_wr_i | input | 1 | Error write strobe |
| err_wdata_i | input | 1 | Error write data (1 clears the flag) |
| cfg_o | output | 4+2*THW | Configuration readback |
| lock_o | output | 1 | Lock bit |
| err_o | output | 1 | Sticky measurement error flag |
| alert_o | output | 1 | Recoverable alert pulse |

## Verification
A wrong internal count or window state shows up on the `err_o` and `alert_o` ports in the cycle after the second reference tick of a window. For this reason the bench sweeps the tick spacing across both bounds and samples exactly there. A window state that was not cleared on disable shows as a spurious alert on the first tick after enabling. A bad lock or configuration register is visible at `cfg_o` and `lock_o` one cycle after the write.

// File: rtl/freq_chk_pkg.sv
package freq_chk_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_ARM  = 2'd1,
    WIN_RUN  = 2'd2
  } win_state_e;

  // Number of bits needed to hold value v.
  function automatic int bit_len(input int v);
    bit_len = $clog2(v + 1);
  endfunction

endpackage

// File: rtl/freq_cfg_regs.sv
module freq_cfg_regs #(
  parameter int RATIO = 16,
  parameter int THW   = 6,
  parameter int CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             lock_wr_i,
  input  logic             lock_wdata_i,
  output logic             en_o,
  output logic [THW-1:0]   max_o,
  output logic [THW-1:0]   min_o,
  output logic             lock_o,
  output logic [CFG_W-1:0] cfg_rd_o
);
  localparam int          MAX_LSB = 4;
  localparam int          MIN_LSB = 4 + THW;
  localparam logic [THW-1:0] RST_MAX = THW'(RATIO + 10);
  localparam logic [THW-1:0] RST_MIN = THW'(RATIO - 10);

  logic           en_q, en_d;
  logic [THW-1:0] max_q, max_d, min_q, min_d;
  logic           lock_q, lock_d;
  logic           cfg_ce, lock_ce;

  // A configuration write lands only while the lock bit is still set.
  assign cfg_ce  = cfg_wr_i & lock_q;
  assign lock_ce = lock_wr_i & ~lock_wdata_i;

  always_comb begin
    en_d   = cfg_wdata_i[0];
    max_d  = cfg_wdata_i[MAX_LSB +: THW];
    min_d  = cfg_wdata_i[MIN_LSB +: THW];
    lock_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      max_q <= RST_MAX;
      min_q <= RST_MIN;
    end else if (cfg_ce) begin
      en_q  <= en_d;
      max_q <= max_d;
      min_q <= min_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (lock_ce) begin
      lock_q <= lock_d;
    end
  end

  assign en_o     = en_q;
  assign max_o    = max_q;
  assign min_o    = min_q;
  assign lock_o   = lock_q;
  assign cfg_rd_o = {min_q, max_q, 3'b000, en_q};

  AST_LOCK_STAYS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> ($stable(en_q) && $stable(max_q) && $stable(min_q))); // R3

endmodule

// File: rtl/freq_win_counter.sv
module freq_win_counter
  import freq_chk_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        tick_i,
  output logic        win_done_o,
  output logic [CW:0] win_cnt_o
);
  localparam logic [CW-1:0] CNT_SAT = {CW{1'b1}};

  win_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_ce;

  // Registers only move while enabled or while leaving an enabled state.
  assign upd_ce = en_i | (st_q != WIN_IDLE) | (cnt_q != '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      st_d  = WIN_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        WIN_RUN: begin
          if (tick_i) begin
            cnt_d = '0;
          end else if (cnt_q != CNT_SAT) begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          // The first tick only opens a window.
          cnt_d = '0;
          st_d  = tick_i ? WIN_RUN : WIN_ARM;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else if (upd_ce) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign win_done_o = en_i & tick_i & (st_q == WIN_RUN);
  assign win_cnt_o  = {1'b0, cnt_q} + (CW + 1)'(1);

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R6
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && cnt_q == CNT_SAT) |=> (cnt_q == CNT_SAT)); // R10
  AST_TICK_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/freq_limit_cmp.sv
module freq_limit_cmp #(
  parameter int THW  = 6,
  parameter int CNTW = 8
) (
  input  logic [CNTW-1:0] cnt_i,
  input  logic [THW-1:0]  max_i,
  input  logic [THW-1:0]  min_i,
  input  logic            valid_i,
  output logic            over_o,
  output logic            under_o,
  output logic            viol_o
);
  logic [CNTW-1:0] max_x, min_x;

  assign max_x   = {{(CNTW-THW){1'b0}}, max_i};
  assign min_x   = {{(CNTW-THW){1'b0}}, min_i};
  assign over_o  = valid_i & (cnt_i > max_x);
  assign under_o = valid_i & (cnt_i < min_x);
  assign viol_o  = over_o | under_o;

endmodule

// File: rtl/freq_err_latch.sv
module freq_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic clr_wdata_i,
  output logic err_o,
  output logic alert_o
);
  logic err_q, err_d, alert_q, alert_d;
  logic clr;

  assign clr = clr_wr_i & clr_wdata_i;

  always_comb begin
    // A hardware set beats a same-cycle clear.
    err_d   = set_i | (err_q & ~clr);
    alert_d = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      err_q   <= err_d;
      alert_q <= alert_d;
    end
  end

  assign err_o   = err_q;
  assign alert_o = alert_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr) |=> err_q); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !set_i) |=> !err_q); // R7
  AST_ALERT_WITH_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_q |-> err_q); // R9

endmodule

// File: rtl/clk_freq_checker.sv
module clk_freq_checker #(
  parameter int RATIO = 16
) (
  input  logic                                               clk_i,
  input  logic                                               rst_ni,
  input  logic                                               ref_tick_i,
  input  logic                                               cfg_wr_i,
  input  logic [4+2*(freq_chk_pkg::bit_len(RATIO)+1)-1:0]    cfg_wdata_i,
  input  logic                                               lock_wr_i,
  input  logic                                               lock_wdata_i,
  input  logic                                               err_wr_i,
  input  logic                                               err_wdata_i,
  output logic [4+2*(freq_chk_pkg::bit_len(RATIO)+1)-1:0]    cfg_o,
  output logic                                               lock_o,
  output logic                                               err_o,
  output logic                                               alert_o
);
  localparam int THW   = freq_chk_pkg::bit_len(RATIO) + 1;
  localparam int CW    = THW + 1;
  localparam int CNTW  = CW + 1;
  localparam int CFG_W = 4 + 2 * THW;

  logic            en;
  logic [THW-1:0]  max_th, min_th;
  logic            win_done;
  logic [CNTW-1:0] win_cnt;
  logic            over, under, viol;

  freq_cfg_regs #(.RATIO(RATIO), .THW(THW), .CFG_W(CFG_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .lock_wr_i    (lock_wr_i),
    .lock_wdata_i (lock_wdata_i),
    .en_o         (en),
    .max_o        (max_th),
    .min_o        (min_th),
    .lock_o       (lock_o),
    .cfg_rd_o     (cfg_o)
  );

  freq_win_counter #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .tick_i     (ref_tick_i),
    .win_done_o (win_done),
    .win_cnt_o  (win_cnt)
  );

  freq_limit_cmp #(.THW(THW), .CNTW(CNTW)) u_cmp (
    .cnt_i   (win_cnt),
    .max_i   (max_th),
    .min_i   (min_th),
    .valid_i (win_done),
    .over_o  (over),
    .under_o (under),
    .viol_o  (viol)
  );

  freq_err_latch u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (viol),
    .clr_wr_i    (err_wr_i),
    .clr_wdata_i (err_wdata_i),
    .err_o       (err_o),
    .alert_o     (alert_o)
  );

  AST_NO_ALERT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !alert_o); // R6
  AST_ALERT_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> $past(ref_tick_i)); // R4
  AST_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(over && under)); // R4

endmodule

// File: tb/clk_freq_checker_tb.sv
module clk_freq_checker_tb;
  localparam int RATIO = 16;
  localparam int THW   = $clog2(RATIO + 1) + 1;
  localparam int CFG_W = 4 + 2 * THW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             lock_wr = 1'b0;
  logic             lock_wdata = 1'b0;
  logic             err_wr = 1'b0;
  logic             err_wdata = 1'b0;
  logic [CFG_W-1:0] cfg_o;
  logic             lock_o, err_o, alert_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  clk_freq_checker #(.RATIO(RATIO)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ref_tick_i   (tick),
    .cfg_wr_i     (cfg_wr),
    .cfg_wdata_i  (cfg_wdata),
    .lock_wr_i    (lock_wr),
    .lock_wdata_i (lock_wdata),
    .err_wr_i     (err_wr),
    .err_wdata_i  (err_wdata),
    .cfg_o        (cfg_o),
    .lock_o       (lock_o),
    .err_o        (err_o),
    .alert_o      (alert_o)
  );

  function automatic logic [CFG_W-1:0] mk_cfg(input int en, input int mx, input int mn);
    int v;
    v = mn * (1 << (4 + THW)) + mx * 16 + en;
    return CFG_W'(v);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [CFG_W-1:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_err(input logic v);
    err_wr = 1'b1; err_wdata = v;
    @(negedge clk);
    err_wr = 1'b0;
  endtask

  task automatic wr_lock(input logic v);
    lock_wr = 1'b1; lock_wdata = v;
    @(negedge clk);
    lock_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // One measured window of p cycles after a fresh enable.
  task automatic run_window(input int p, input int mn, input int mx);
    int viol;
    viol = ((p > mx) || (p < mn)) ? 1 : 0;
    wr_cfg(mk_cfg(0, mx, mn));
    wr_err(1'b1);
    wr_cfg(mk_cfg(1, mx, mn));
    pulse_tick();
    chk("R5 first tick alert", alert_o, 0);
    chk("R5 first tick err", err_o, 0);
    idle(p - 1);
    pulse_tick();
    chk($sformatf("R4 alert p=%0d", p), alert_o, viol);
    chk($sformatf("R4 err p=%0d", p), err_o, viol);
    idle(1);
    chk("R9 alert one cycle", alert_o, 0);
    chk("R7 err held", err_o, viol);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 cfg", int'(cfg_o), int'(mk_cfg(0, RATIO + 10, RATIO - 10)));
    chk("R1 lock", lock_o, 1);
    chk("R1 err", err_o, 0);
    chk("R1 alert", alert_o, 0);

    // R4 sweep around default bounds
    for (int p = 1; p <= 40; p++) run_window(p, RATIO - 10, RATIO + 10);
    // R4 equality boundaries with a single legal count
    for (int p = 8; p <= 12; p++) run_window(p, 10, 10);
    // R10 saturating counter on very long windows
    run_window(130, RATIO - 10, RATIO + 10);
    run_window(200, 0, (1 << THW) - 1);

    // R6 disabled: ticks do nothing
    wr_err(1'b1);
    wr_cfg(mk_cfg(0, 10, 10));
    for (int k = 0; k < 5; k++) begin
      pulse_tick();
      chk("R6 alert while off", alert_o, 0);
      chk("R6 err while off", err_o, 0);
      idle(2);
    end

    // R8 set beats clear, R9 alert when flag already set
    wr_cfg(mk_cfg(1, 10, 10));
    pulse_tick();
    idle(2);
    pulse_tick();
    chk("R8 pre err", err_o, 1);
    idle(2);
    tick = 1'b1; err_wr = 1'b1; err_wdata = 1'b1;
    @(negedge clk);
    tick = 1'b0; err_wr = 1'b0;
    chk("R8 set wins err", err_o, 1);
    chk("R9 alert again", alert_o, 1);
    // R7 write 0 no effect, write 1 clears
    wr_cfg(mk_cfg(0, 10, 10));
    wr_err(1'b0);
    chk("R7 write0 keeps", err_o, 1);
    wr_err(1'b1);
    chk("R7 write1 clears", err_o, 0);

    // R2 layout and R3 lock
    wr_lock(1'b1);
    chk("R3 lock write1", lock_o, 1);
    wr_cfg(mk_cfg(1, 33, 5) | CFG_W'(14));
    chk("R2 layout", int'(cfg_o), int'(mk_cfg(1, 33, 5)));
    wr_lock(1'b0);
    chk("R3 lock cleared", lock_o, 0);
    wr_cfg(mk_cfg(0, 20, 12));
    chk("R3 cfg ignored", int'(cfg_o), int'(mk_cfg(1, 33, 5)));
    wr_lock(1'b1);
    chk("R3 lock no rearm", lock_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule